// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Compare

This block is a purely combinational integer ALU. It is built from one repeated single-bit slice, and the slices are chained by a ripple carry. A 3-bit control word chooses one of five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

The top control bit is a single negate line. When it is high, every slice inverts its b operand and the lowest slice receives a carry-in of one, so the adder forms a + ~b + 1. The compare function uses that subtraction. The corrected sign of the difference, taken at the top slice, is routed back into a spare mux input of the lowest slice. All other slices receive zero on that input.

Alongside the result the block drives three flags:
- a zero flag, which lets an equality branch be resolved by subtracting,
- a signed overflow flag,
- the carry out of the top slice.

It is meant for the execute stage of a simple integer datapath. Operands and control are presented, and the outputs settle within the same cycle.

Top module: `slice_alu`

## Requirements
- R1: Control 000 gives res_o equal to the bitwise AND of a_i and b_i.
- R2: Control 001 gives res_o equal to the bitwise OR of a_i and b_i.
- R3: Control 010 gives res_o equal to (a_i + b_i) modulo 2^WIDTH.
- R4: Control 110 gives res_o equal to (a_i - b_i) modulo 2^WIDTH.
- R5: Control 111 gives res_o equal to 1 when a_i is less than b_i as signed two's complement values, and 0 otherwise. This holds even when a_i - b_i overflows. Bits WIDTH-1 down to 1 are always 0 for this code.
- R6: zero_o is 1 exactly when every bit of res_o is 0, for every control value.
- R7: For controls 010 and 110, ovf_o is 1 exactly when the signed sum or difference lies outside the signed WIDTH-bit range. For every other control value ovf_o is 0.
- R8: When control bit 2 is 0, carry_o is 1 exactly when the unsigned sum a_i + b_i is at least 2^WIDTH. When control bit 2 is 1, carry_o is 1 exactly when the unsigned a_i is at least the unsigned b_i. This holds for all control values.
- R9: The unlisted controls 011, 100 and 101 give res_o of all zeros, so zero_o is 1 and ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| ctl_i | input | 3 | Function select: bit 2 is the negate line, bits 1:0 select the slice mux input |
| res_o | output | WIDTH | Function result |
| zero_o | output | 1 | High when res_o is all zeros |
| ovf_o | output | 1 | Signed overflow of an add or a subtract |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
The bench focuses on compares where a - b overflows, such as the most negative value against a positive one. A design that takes the raw adder sign as the less-than answer reports the wrong ordering for exactly these pairs. Equal operands under subtraction must give zero_o high and carry_o high. A slice chain that injected the negate carry without inverting b, or the reverse, is off by one or by a complement here. Unlisted codes and the logical functions must keep ovf_o low, which exposes overflow logic left ungated. A 6-bit copy of the block is swept over every operand pair and every control code, and the 32-bit default is driven with boundary operands and random ones.

// File: rtl/alu_pkg.sv
package alu_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } sel_e;

  localparam logic [2:0] CTL_AND = 3'b000;
  localparam logic [2:0] CTL_OR  = 3'b001;
  localparam logic [2:0] CTL_ADD = 3'b010;
  localparam logic [2:0] CTL_SUB = 3'b110;
  localparam logic [2:0] CTL_SLT = 3'b111;

  function automatic logic ctl_known(input logic [2:0] ctl);
    return (ctl == CTL_AND) || (ctl == CTL_OR) || (ctl == CTL_ADD) ||
           (ctl == CTL_SUB) || (ctl == CTL_SLT);
  endfunction
endpackage

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
  import alu_pkg::*;
(
  input  logic [2:0] ctl_i,
  output logic       neg_o,
  output sel_e       sel_o,
  output logic       en_o,
  output logic       arith_o
);
  timeunit 1ns;
  timeprecision 100ps;

  always_comb begin
    neg_o   = ctl_i[2];
    sel_o   = sel_e'(ctl_i[1:0]);
    en_o    = ctl_known(ctl_i);
    arith_o = (ctl_i == CTL_ADD) || (ctl_i == CTL_SUB);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic neg_i,
  input  logic cin_i,
  input  logic less_i,
  input  sel_e sel_i,
  input  logic en_i,
  output logic sum_o,
  output logic cout_o,
  output logic res_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic b_eff;
  logic mux_out;

  assign b_eff  = b_i ^ neg_i;
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  mux_out = a_i & b_i;
      SEL_OR:   mux_out = a_i | b_i;
      SEL_SUM:  mux_out = sum_o;
      SEL_LESS: mux_out = less_i;
      default:  mux_out = 1'b0;
    endcase
  end

  // unlisted control codes force the slice output low
  assign res_o = en_i & mux_out;
endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags (
  input  logic cin_msb_i,
  input  logic cout_msb_i,
  input  logic sum_msb_i,
  input  logic arith_i,
  output logic set_o,
  output logic ovf_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic ovf_raw;

  assign ovf_raw = cin_msb_i ^ cout_msb_i;
  // sign corrected for overflow keeps signed compare exact
  assign set_o   = sum_msb_i ^ ovf_raw;
  assign ovf_o   = arith_i & ovf_raw;
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  timeunit 1ns;
  timeprecision 100ps;

  assign zero_o = ~(|val_i);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       ctl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned MSB = WIDTH - 1;

  logic neg;
  sel_e sel;
  logic en;
  logic arith;
  logic set_fb;

  alu_ctl_dec u_dec (
    .ctl_i   (ctl_i),
    .neg_o   (neg),
    .sel_o   (sel),
    .en_o    (en),
    .arith_o (arith)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : gen_slice
    logic cin;
    logic cout;
    logic sum;
    logic less;
    logic res;

    if (i == 0) begin : gen_lsb
      assign cin  = neg;
      assign less = set_fb;
    end else begin : gen_upper
      assign cin  = gen_slice[i-1].cout;
      assign less = 1'b0;
    end

    alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .neg_i  (neg),
      .cin_i  (cin),
      .less_i (less),
      .sel_i  (sel),
      .en_i   (en),
      .sum_o  (sum),
      .cout_o (cout),
      .res_o  (res)
    );

    assign res_o[i] = res;
  end

  alu_msb_flags u_msb (
    .cin_msb_i  (gen_slice[MSB].cin),
    .cout_msb_i (gen_slice[MSB].cout),
    .sum_msb_i  (gen_slice[MSB].sum),
    .arith_i    (arith),
    .set_o      (set_fb),
    .ovf_o      (ovf_o)
  );

  assign carry_o = gen_slice[MSB].cout;

  alu_zero_det #(.WIDTH(WIDTH)) u_zero (
    .val_i  (res_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       ctl_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             carry_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic known;
  assign known = !$isunknown({a_i, b_i, ctl_i, res_o, zero_o, ovf_o, carry_o});

  always_comb begin
    if (known) begin
      // R6
      zero_flag_chk: assert (zero_o == (res_o == '0));
      // R7
      no_overflow_chk: assert (!((ctl_i != 3'b010) && (ctl_i != 3'b110)) || !ovf_o);
      // R5
      slt_upper_chk: assert ((ctl_i != 3'b111) || (res_o[WIDTH-1:1] == '0));
      // R9
      bad_code_chk: assert (!((ctl_i == 3'b011) || (ctl_i == 3'b100) ||
                              (ctl_i == 3'b101)) || (res_o == '0));
      // R1
      and_fn_chk: assert ((ctl_i != 3'b000) || (res_o == (a_i & b_i)));
      // R8
      equal_carry_chk: assert (!(ctl_i[2] && (a_i == b_i)) || carry_o);
      // R4
      sub_equal_chk: assert (!((ctl_i == 3'b110) && (a_i == b_i)) || zero_o);
    end
  end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .ctl_i   (ctl_i),
  .res_o   (res_o),
  .zero_o  (zero_o),
  .ovf_o   (ovf_o),
  .carry_o (carry_o)
);

// File: tb/tb_slice_alu.sv
module tb_slice_alu;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned WL = 32;
  localparam int unsigned WS = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [WL-1:0] a_l, b_l, res_l;
  logic [2:0]    ctl_l;
  logic          z_l, o_l, c_l;
  logic [WS-1:0] a_s, b_s, res_s;
  logic [2:0]    ctl_s;
  logic          z_s, o_s, c_s;

  int n_run = 0;
  int n_fail = 0;

  slice_alu #(.WIDTH(WL)) dut (
    .a_i(a_l), .b_i(b_l), .ctl_i(ctl_l),
    .res_o(res_l), .zero_o(z_l), .ovf_o(o_l), .carry_o(c_l)
  );

  slice_alu #(.WIDTH(WS)) dut_small (
    .a_i(a_s), .b_i(b_s), .ctl_i(ctl_s),
    .res_o(res_s), .zero_o(z_s), .ovf_o(o_s), .carry_o(c_s)
  );

  function automatic string res_tag(input logic [2:0] ctl);
    case (ctl)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input longint act,
                     input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // arithmetic reference on integers
  task automatic check(input int w, input longint ua, input longint ub,
                       input logic [2:0] ctl, input longint ar, input bit az,
                       input bit ao, input bit ac);
    longint md, half, sa, sb, s, r;
    bit o, c;
    md   = longint'(1) << w;
    half = md / 2;
    sa   = (ua >= half) ? ua - md : ua;
    sb   = (ub >= half) ? ub - md : ub;
    s    = 0;
    case (ctl)
      3'b000: r = ua & ub;
      3'b001: r = ua | ub;
      3'b010: begin s = sa + sb; r = (ua + ub) % md; end
      3'b110: begin s = sa - sb; r = (ua - ub + md) % md; end
      3'b111: r = (sa < sb) ? 1 : 0;
      default: r = 0;
    endcase
    o = ((ctl == 3'b010) || (ctl == 3'b110)) && ((s < -half) || (s >= half));
    c = ctl[2] ? (ua >= ub) : ((ua + ub) >= md);
    cmp(res_tag(ctl), "result", ar, r);
    cmp("R6", "zero", longint'(az), longint'(r == 0));
    cmp((ctl == 3'b010 || ctl == 3'b110) ? "R7" : "R7/R9", "overflow",
        longint'(ao), longint'(o));
    cmp("R8", "carry", longint'(ac), longint'(c));
  endtask

  task automatic run_l(input logic [WL-1:0] a, input logic [WL-1:0] b,
                       input logic [2:0] ctl);
    @(posedge clk);
    a_l = a; b_l = b; ctl_l = ctl;
    @(negedge clk);
    check(WL, longint'(a), longint'(b), ctl, longint'(res_l), z_l, o_l, c_l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [WL-1:0] corner [7];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h8000_0001;
    corner[6] = 32'h5555_5555;
    a_l = '0; b_l = '0; ctl_l = 3'b000;
    a_s = '0; b_s = '0; ctl_s = 3'b000;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // initial state with idle inputs: result 0, zero high (R6)
    cmp("R6", "idle result", longint'(res_l), 0);
    cmp("R6", "idle zero", longint'(z_l), 1);

    // compare overflow cases (R5): min vs positive, max vs negative
    run_l(32'h8000_0000, 32'h0000_0001, 3'b111);
    cmp("R5", "min<1", longint'(res_l), 1);
    run_l(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    cmp("R5", "max<-1", longint'(res_l), 0);
    // equal subtract (R4, R8)
    run_l(32'h1234_5678, 32'h1234_5678, 3'b110);
    cmp("R4", "eq zero", longint'(z_l), 1);
    cmp("R8", "eq carry", longint'(c_l), 1);

    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        for (int k = 0; k < 8; k++)
          run_l(corner[i], corner[j], 3'(k));

    for (int n = 0; n < 1500; n++)
      for (int k = 0; k < 8; k++)
        run_l($urandom, $urandom, 3'(k));

    // exhaustive sweep of the small configuration (R1..R9)
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < (1 << WS); i++)
        for (int j = 0; j < (1 << WS); j++) begin
          @(posedge clk);
          a_s = WS'(i); b_s = WS'(j); ctl_s = 3'(k);
          @(negedge clk);
          check(WS, longint'(i), longint'(j), 3'(k), longint'(res_s), z_s, o_s, c_s);
        end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule